// File: doc/BRIEF.md
# Software-Occupancy Counter Filter

This block guards the allocation of hardware synchronization entries. It keeps a small array of counters, one per group of synchronization addresses. Each counter records how many threads are waiting on, or holding, an address of its group that is being served by the software fallback path. The counter is picked by a few low address bits and has no tag, so several addresses share one counter. The filter may therefore refuse an allocation that would have been safe. It never allows one while software still has activity on that address.

The block is consulted only after the entry table has missed. An acquire that misses asks whether it may allocate. The answer is yes only when the table has a free slot and the indexed counter is zero. Otherwise the request is steered to software and the counter goes up by one.

Software-side completions bring the counter down. These are a release that misses the table, or an explicit finish notice after a software barrier or condition wait. A bulk-add command raises a counter by any amount in one cycle. It is used when a migration aborts a whole group of hardware waiters into software.

Top module: `ovf_count_filter`

## Requirements
- R1: After reset every counter is zero and `err_sticky` is low, so a missing acquire with a free table slot is granted allocation.
- R2: The counter is selected by address bits `[IDX_LSB +: 2]` (bits 3:2 by default, four counters) and no other address bits are compared, so aliasing addresses share state.
- R3: An acquire that misses (`acq_valid=1`, `acq_hit=0`) and is not granted raises `acq_fallback` in the same cycle and adds one to its counter at the next clock edge.
- R4: `acq_alloc` is high only for a missing acquire whose counter is zero while `table_full` is low, and a granted allocation leaves the counter unchanged.
- R5: An acquire with `acq_hit=1` raises neither output and changes no counter, and a release with `rel_hit=1` changes no counter.
- R6: A release that misses (`rel_valid=1`, `rel_hit=0`) subtracts one from its counter.
- R7: A finish notice (`fin_valid=1`) subtracts one from its counter.
- R8: A bulk add (`bulk_valid=1`) adds `bulk_count` to its counter in a single cycle.
- R9: A counter saturates at `2**CTR_W-1` and does not wrap.
- R10: A net decrease below zero leaves the counter at zero and sets `err_sticky`, which stays high until reset.
- R11: All commands in one cycle are summed into a single net change per counter, and the allocation decision in that cycle uses the count from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | Acquire-type request present |
| acq_addr | input | ADDR_W | Acquire synchronization address |
| acq_hit | input | 1 | Entry table hit for the acquire |
| table_full | input | 1 | No free entry in the table |
| acq_alloc | output | 1 | Acquire may allocate a hardware entry |
| acq_fallback | output | 1 | Acquire steered to software (counter increments) |
| rel_valid | input | 1 | Release request present |
| rel_addr | input | ADDR_W | Release address |
| rel_hit | input | 1 | Entry table hit for the release |
| fin_valid | input | 1 | Software completion notice |
| fin_addr | input | ADDR_W | Completion address |
| bulk_valid | input | 1 | Bulk add command |
| bulk_addr | input | ADDR_W | Bulk add address |
| bulk_count | input | CTR_W | Amount to add |
| err_sticky | output | 1 | Underflow seen since reset |

## Verification
The bench drives aliasing addresses so that a refusal on one address must block the other. A design that compares extra address bits would grant allocation there. It loads a counter to its ceiling and pushes one more increment, then drains it one short of zero. A wrapping counter would grant allocation too early. It issues finishes on an empty counter to check that the count stays at zero and the error flag latches, since a design that wraps would refuse allocation afterwards. Increments, decrements and queries also land in the same cycle. A design that applied only one of them, or that let the query see the updated value, diverges from the reference model on the following cycle.

// File: rtl/ovf_count_filter.sv
module ovf_count_filter #(
  parameter int ADDR_W  = 16,
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 4,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_valid,
  input  logic [ADDR_W-1:0] acq_addr,
  input  logic              acq_hit,
  input  logic              table_full,
  output logic              acq_alloc,
  output logic              acq_fallback,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_addr,
  input  logic              rel_hit,
  input  logic              fin_valid,
  input  logic [ADDR_W-1:0] fin_addr,
  input  logic              bulk_valid,
  input  logic [ADDR_W-1:0] bulk_addr,
  input  logic [CTR_W-1:0]  bulk_count,
  output logic              err_sticky
);
  localparam int IDX_W = $clog2(NUM_CTR);
  localparam int SUM_W = CTR_W + 2;
  localparam logic [SUM_W-1:0] CMAX = SUM_W'((1 << CTR_W) - 1);

  logic [CTR_W-1:0] cnt [NUM_CTR];
  logic [NUM_CTR-1:0] under;

  wire [IDX_W-1:0] a_idx = acq_addr[IDX_LSB +: IDX_W];
  wire [IDX_W-1:0] r_idx = rel_addr[IDX_LSB +: IDX_W];
  wire [IDX_W-1:0] f_idx = fin_addr[IDX_LSB +: IDX_W];
  wire [IDX_W-1:0] b_idx = bulk_addr[IDX_LSB +: IDX_W];

  wire miss = acq_valid && !acq_hit;
  assign acq_alloc    = miss && !table_full && (cnt[a_idx] == '0);
  assign acq_fallback = miss && !acq_alloc;
  wire rel_sw = rel_valid && !rel_hit;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [SUM_W-1:0] plus, minus, total;
    logic [CTR_W-1:0] nxt;
    always_comb begin
      plus  = SUM_W'(acq_fallback && a_idx == IDX_W'(i))
            + ((bulk_valid && b_idx == IDX_W'(i)) ? SUM_W'(bulk_count) : '0);
      minus = SUM_W'(rel_sw && r_idx == IDX_W'(i))
            + SUM_W'(fin_valid && f_idx == IDX_W'(i));
      total = SUM_W'(cnt[i]) + plus;
      under[i] = total < minus;
      if (under[i])                nxt = '0;
      else if (total - minus > CMAX) nxt = CMAX[CTR_W-1:0];
      else                         nxt = CTR_W'(total - minus);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[i] <= '0;
      else        cnt[i] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_sticky <= 1'b0;
    else if (|under)  err_sticky <= 1'b1;
  end
endmodule

// File: rtl/ovf_count_filter_chk.sv
module ovf_count_filter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acq_valid,
  input logic [ADDR_W-1:0] acq_addr,
  input logic              acq_hit,
  input logic              table_full,
  input logic              acq_alloc,
  input logic              acq_fallback,
  input logic              rel_valid,
  input logic              rel_hit,
  input logic              fin_valid,
  input logic              err_sticky
);
  p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && acq_hit) |-> (!acq_alloc && !acq_fallback));

  p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    table_full |-> !acq_alloc);

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_alloc && acq_fallback));

  p_err_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  p_refused_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_fallback && !(rel_valid && !rel_hit) && !fin_valid)
      |=> !(acq_valid && !acq_hit && acq_addr == $past(acq_addr) && acq_alloc));
endmodule

bind ovf_count_filter ovf_count_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_addr(acq_addr),
  .acq_hit(acq_hit), .table_full(table_full), .acq_alloc(acq_alloc),
  .acq_fallback(acq_fallback), .rel_valid(rel_valid), .rel_hit(rel_hit),
  .fin_valid(fin_valid), .err_sticky(err_sticky)
);

// File: tb/ovf_count_filter_test.sv
module ovf_count_filter_test;
  localparam int AW = 16;
  localparam int NC = 4;
  localparam int CW = 4;
  localparam int LSB = 2;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic acq_valid = 0, acq_hit = 0, table_full = 0;
  logic [AW-1:0] acq_addr = '0, rel_addr = '0, fin_addr = '0, bulk_addr = '0;
  logic rel_valid = 0, rel_hit = 0, fin_valid = 0, bulk_valid = 0;
  logic [CW-1:0] bulk_count = '0;
  logic acq_alloc, acq_fallback, err_sticky;

  always #4 clk = ~clk;

  ovf_count_filter #(.ADDR_W(AW), .NUM_CTR(NC), .CTR_W(CW), .IDX_LSB(LSB)) uut (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_addr(acq_addr),
    .acq_hit(acq_hit), .table_full(table_full), .acq_alloc(acq_alloc),
    .acq_fallback(acq_fallback), .rel_valid(rel_valid), .rel_addr(rel_addr),
    .rel_hit(rel_hit), .fin_valid(fin_valid), .fin_addr(fin_addr),
    .bulk_valid(bulk_valid), .bulk_addr(bulk_addr), .bulk_count(bulk_count),
    .err_sticky(err_sticky));

  int n_run = 0, n_fail = 0;
  int model [NC];
  bit m_err = 0;

  function automatic int ix(logic [AW-1:0] a);
    return (int'(a) >> LSB) % NC;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag,
                      bit av, logic [AW-1:0] aa, bit ah, bit full,
                      bit rv, logic [AW-1:0] ra, bit rh,
                      bit fv, logic [AW-1:0] fa,
                      bit bv, logic [AW-1:0] ba, int bc);
    bit e_alloc, e_fb;
    @(negedge clk);
    acq_valid = av; acq_addr = aa; acq_hit = ah; table_full = full;
    rel_valid = rv; rel_addr = ra; rel_hit = rh;
    fin_valid = fv; fin_addr = fa;
    bulk_valid = bv; bulk_addr = ba; bulk_count = CW'(bc);
    #1;
    e_alloc = av && !ah && !full && model[ix(aa)] == 0;
    e_fb    = av && !ah && !e_alloc;
    chk(tag, "acq_alloc", int'(acq_alloc), int'(e_alloc));
    chk(tag, "acq_fallback", int'(acq_fallback), int'(e_fb));
    @(posedge clk);
    for (int i = 0; i < NC; i++) begin
      int t;
      t = model[i];
      if (e_fb && ix(aa) == i) t++;
      if (bv && ix(ba) == i) t += bc;
      if (rv && !rh && ix(ra) == i) t--;
      if (fv && ix(fa) == i) t--;
      if (t < 0) begin t = 0; m_err = 1; end
      if (t > MAXC) t = MAXC;
      model[i] = t;
    end
    #1;
    chk(tag, "err_sticky", int'(err_sticky), int'(m_err));
  endtask

  task automatic acq(string tag, logic [AW-1:0] a, bit full);
    step(tag, 1, a, 0, full, 0, '0, 0, 0, '0, 0, '0, 0);
  endtask
  task automatic fin(string tag, logic [AW-1:0] a);
    step(tag, 0, '0, 0, 0, 0, '0, 0, 1, a, 0, '0, 0);
  endtask

  localparam logic [AW-1:0] A  = 16'h0010;
  localparam logic [AW-1:0] A2 = 16'h1230;
  localparam logic [AW-1:0] B  = 16'h0004;
  localparam logic [AW-1:0] C  = 16'h0008;

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    step("R1", 1, A, 0, 0, 0, '0, 0, 0, '0, 0, '0, 0);
    // R3 refused by full table, R2 alias shares counter
    acq("R3", A, 1);
    acq("R2", A2, 0);
    // R4 grant leaves counter at zero
    acq("R4", B, 0);
    acq("R4", B, 0);
    // R5 hits have no effect
    step("R5", 1, A, 1, 0, 0, '0, 0, 0, '0, 0, '0, 0);
    step("R5", 0, '0, 0, 0, 1, A, 1, 0, '0, 0, '0, 0);
    acq("R5", B, 0);
    // R6 / R7 decrements
    step("R6", 0, '0, 0, 0, 1, A, 0, 0, '0, 0, '0, 0);
    fin("R7", A2);
    acq("R7", A, 0);
    // R8 bulk add, then drain two at a time
    step("R8", 0, '0, 0, 0, 0, '0, 0, 0, '0, 1, B, 5);
    acq("R8", B, 0);
    for (int k = 0; k < 3; k++)
      step("R8", 0, '0, 0, 0, 1, B, 0, 1, B, 0, '0, 0);
    acq("R8", B, 0);
    // R9 saturation
    step("R9", 0, '0, 0, 0, 0, '0, 0, 0, '0, 1, A, MAXC);
    acq("R9", A, 1);
    for (int k = 0; k < MAXC - 1; k++) fin("R9", A);
    acq("R9", A, 0);
    for (int k = 0; k < 2; k++) fin("R9", A2);
    acq("R9", A, 0);
    // R10 underflow clamps and latches
    fin("R10", C);
    acq("R10", C, 0);
    step("R10", 0, '0, 0, 0, 1, C, 0, 1, C, 0, '0, 0);
    acq("R10", C, 0);
    // R11 same-cycle net change, pre-edge query
    step("R11", 1, A, 0, 1, 0, '0, 0, 1, A, 0, '0, 0);
    acq("R11", A, 0);
    acq("R11", C, 1);
    step("R11", 1, C, 0, 0, 1, C, 0, 0, '0, 0, '0, 0);
    acq("R11", C, 0);
    fin("R11", C);
    acq("R11", C, 0);
    step("R11", 1, B, 0, 1, 0, '0, 0, 0, '0, 1, B, 3);
    for (int k = 0; k < 2; k++)
      step("R11", 0, '0, 0, 0, 1, B, 0, 1, B, 0, '0, 0);
    acq("R11", B, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule